// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register side of a single DMA channel. A processor reaches it over a 32-bit register bus that takes whole-word accesses only. It holds four registers: control/status, transfer address, byte count and a high-address extension. The unit does not move any data itself. It tells the attached peripheral when to reset and when DMA is enabled. It gates the peripheral's interrupt level into a single interrupt line. It also advances the address register by the byte length of each transfer that the peripheral reports as complete.

Writes to the control register have side effects that depend on the value written. Two small state machines carry those effects. The reset-pulse machine has the states PS_IDLE and PS_FIRE. It moves from PS_IDLE to PS_FIRE on a control write with the reset bit set (transition "fire"). It stays in PS_FIRE while such writes continue back to back, and otherwise returns to PS_IDLE (transition "expire"). The enable machine has the states EN_OFF and EN_ON. It moves from EN_OFF to EN_ON on a control write with the enable bit set (transition "rise"). It moves from EN_ON to EN_OFF on a control write with that bit clear (transition "fall"). Any other cycle leaves it where it is.

Register index = byte address bits [3:2]. Address bits above bit 3 are ignored, so the four registers repeat across the address space and the window works at any 16-byte-aligned offset. Byte address bits [1:0] are ignored. Control register fields:

| Bit | Field |
|-----|-------|
| 0 | interrupt pending |
| 4 | interrupt enable |
| 6 | drain |
| 7 | peripheral reset |
| 8 | direction (write to memory) |
| 9 | DMA enable |
| 26 | address loaded |

Read-only bits are those in the mask 0xFE000007. Bits 31 and 29 always read as 1; they form the version field.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control register reads 0xA0000000, the other three registers read 0, and `irq_out`, `periph_rst` and `dma_en` are 0.
- R2: Each register is selected by byte address bits [3:2], with 0 = control, 1 = address, 2 = count and 3 = high address. All other address bits have no effect on the selection.
- R3: A control write leaves unchanged every bit in the mask 0xFE000007. Bits 31 and 29 always read as 1. All other bits take the value written, subject to R7.
- R4: The pending bit (bit 0) equals the level that `periph_irq` had at the previous clock edge. A bus write cannot change it.
- R5: `irq_out` is high exactly when the pending bit and the interrupt-enable bit (bit 4) are both set. It follows a control write or a change of the pending bit one cycle later.
- R6: A control write with bit 7 set makes `periph_rst` high for exactly the next cycle. Without another such write, `periph_rst` is low in the cycle after that.
- R7: When bit 7 is clear, a control write with bit 6 set stores bit 6 as 0. A control write of 0x00000000 stores bit 6 as 1.
- R8: `dma_en` equals control bit 9. It rises in the cycle after a control write that sets bit 9 and falls in the cycle after a control write that clears it.
- R9: Any word write to the address register also sets control bit 26. The bit then stays set until reset.
- R10: When `xfer_done` is high, the address register grows by `xfer_len`. A word write to the address register in the same cycle takes precedence.
- R11: Any access with `bus_size` other than 2'b10 (a 4-byte word) has no effect. On a read it returns 0.
- R12: The count and high-address registers read back the last word written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe |
| bus_addr | input | ADDR_W | byte address |
| bus_size | input | 2 | access size code; 2'b10 = 4-byte word |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational |
| periph_irq | input | 1 | interrupt level from the peripheral |
| xfer_done | input | 1 | peripheral finished one transfer |
| xfer_len | input | LEN_W | byte length of that transfer |
| irq_out | output | 1 | gated level interrupt |
| periph_rst | output | 1 | one-cycle reset pulse to the peripheral |
| dma_en | output | 1 | DMA enable level to the peripheral |

## Verification
All state in this block can be read back, so any corruption shows up at the ports. A wrong stored bit shows on the very next word read. A wrong enable or pulse state shows one cycle after the control write that caused it. A stale pending bit appears as a wrong `irq_out` in the cycle after `periph_irq` changes. An address register that advances wrongly, or misses an advance, differs on the first read after the transfer. The enable machine keeps its own copy of bit 9, so a split between that copy and the stored bit shows as a mismatch between `dma_en` and the bit on any control read.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int DATA_W   = 32;
    localparam int WIN_BITS = 4;
    localparam logic [1:0] SIZE_WORD = 2'b10;
    localparam logic [DATA_W-1:0] RO_MASK  = 32'hFE00_0007;
    localparam logic [DATA_W-1:0] VER_BITS = 32'hA000_0000;

    localparam int B_PEND   = 0;
    localparam int B_IEN    = 4;
    localparam int B_DRAIN  = 6;
    localparam int B_RST    = 7;
    localparam int B_DIR    = 8;
    localparam int B_EN     = 9;
    localparam int B_LOADED = 26;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_ADDR  = 2'd1,
        REG_COUNT = 2'd2,
        REG_HIGH  = 2'd3
    } reg_idx_e;

    typedef enum logic { PS_IDLE, PS_FIRE } pulse_st_e;
    typedef enum logic { EN_OFF, EN_ON } en_st_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_idx_e idx;
    } acc_s;
endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output acc_s              acc
);
    logic is_word;
    logic unused_addr_bits;

    assign is_word          = (bus_size == SIZE_WORD);
    assign unused_addr_bits = ^{bus_addr[ADDR_W-1:WIN_BITS], bus_addr[1:0]};

    always_comb begin
        acc.wr  = bus_wr & is_word;
        acc.rd  = bus_rd & is_word;
        acc.idx = reg_idx_e'(bus_addr[WIN_BITS-1:2]);
    end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              set_loaded,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_level,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              fire_rst,
    output logic              irq_gate
);
    logic [DATA_W-1:0] body_q;
    logic [DATA_W-1:0] shaped;
    logic              pend_q;

    always_comb begin
        shaped   = wdata;
        fire_rst = wr_ctrl & wdata[B_RST];
        if (!wdata[B_RST]) begin
            if (wdata[B_DRAIN]) begin
                shaped[B_DRAIN] = 1'b0;
            end else if (wdata == '0) begin
                shaped[B_DRAIN] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            body_q <= VER_BITS;
        end else begin
            if (wr_ctrl) begin
                body_q <= (body_q & RO_MASK) | (shaped & ~RO_MASK) | VER_BITS;
            end else if (set_loaded) begin
                body_q[B_LOADED] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= irq_level;
    end

    always_comb begin
        ctrl_q         = body_q;
        ctrl_q[B_PEND] = pend_q;
    end

    assign irq_gate = pend_q & body_q[B_IEN];
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_rst,
    input  logic wr_ctrl,
    input  logic en_bit,
    output logic periph_rst,
    output logic dma_en
);
    pulse_st_e ps_q, ps_d;
    en_st_e    es_q, es_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= PS_IDLE;
            es_q <= EN_OFF;
        end else begin
            ps_q <= ps_d;
            es_q <= es_d;
        end
    end

    always_comb begin
        ps_d = ps_q;
        unique case (ps_q)
            PS_IDLE: if (fire_rst) ps_d = PS_FIRE;
            PS_FIRE: if (!fire_rst) ps_d = PS_IDLE;
            default: ps_d = PS_IDLE;
        endcase
        es_d = es_q;
        unique case (es_q)
            EN_OFF:  if (wr_ctrl && en_bit)  es_d = EN_ON;
            EN_ON:   if (wr_ctrl && !en_bit) es_d = EN_OFF;
            default: es_d = EN_OFF;
        endcase
    end

    always_comb begin
        periph_rst = (ps_q == PS_FIRE);
        dma_en     = (es_q == EN_ON);
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              periph_irq,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              irq_out,
    output logic              periph_rst,
    output logic              dma_en
);
    localparam int NREG      = 4;
    localparam int FIRST_RAW = 2;

    acc_s              acc;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] raw_q [NREG];
    logic              fire_rst;
    logic              wr_ctrl;
    logic              wr_addr;

    dma_chan_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .bus_size(bus_size),
        .acc     (acc)
    );

    assign wr_ctrl = acc.wr && (acc.idx == REG_CTRL);
    assign wr_addr = acc.wr && (acc.idx == REG_ADDR);

    dma_chan_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .set_loaded(wr_addr),
        .wdata     (bus_wdata),
        .irq_level (periph_irq),
        .ctrl_q    (ctrl_q),
        .fire_rst  (fire_rst),
        .irq_gate  (irq_out)
    );

    dma_chan_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_rst  (fire_rst),
        .wr_ctrl   (wr_ctrl),
        .en_bit    (bus_wdata[B_EN]),
        .periph_rst(periph_rst),
        .dma_en    (dma_en)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_addr) begin
            addr_q <= bus_wdata;
        end else if (xfer_done) begin
            addr_q <= addr_q + DATA_W'(xfer_len);
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_raw
        if (g >= FIRST_RAW) begin : g_store
            always_ff @(posedge clk) begin
                if (!rst_n) raw_q[g] <= '0;
                else if (acc.wr && (acc.idx == reg_idx_e'(g))) raw_q[g] <= bus_wdata;
            end
        end else begin : g_none
            assign raw_q[g] = '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            unique case (acc.idx)
                REG_CTRL:  bus_rdata = ctrl_q;
                REG_ADDR:  bus_rdata = addr_q;
                REG_COUNT: bus_rdata = raw_q[REG_COUNT];
                REG_HIGH:  bus_rdata = raw_q[REG_HIGH];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              periph_irq,
    input logic              irq_out,
    input logic              periph_rst,
    input logic              dma_en
);
    logic ctrl_wr, ctrl_rd, unused_chk;
    assign ctrl_wr    = bus_wr && bus_size == 2'b10 && bus_addr[3:2] == 2'd0;
    assign ctrl_rd    = bus_rd && bus_size == 2'b10 && bus_addr[3:2] == 2'd0;
    assign unused_chk = ^{bus_addr[ADDR_W-1:4], bus_addr[1:0]};

    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst |-> $past(ctrl_wr && bus_wdata[7]));
    assert_pulse_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[7]) |=> periph_rst);
    assert_irq_needs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(periph_irq));
    assert_irq_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |-> (irq_out == (bus_rdata[0] && bus_rdata[4])));
    assert_en_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |-> (bus_rdata[9] == dma_en));
    assert_en_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_en) |-> $past(ctrl_wr && bus_wdata[9]));
    assert_version_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |-> (bus_rdata[31:29] == 3'b101));
    assert_nonword_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size != 2'b10) |-> (bus_rdata == 32'd0));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 16;
    localparam logic [31:0] RO  = 32'hFE00_0007;
    localparam logic [31:0] VER = 32'hA000_0000;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0] bus_size = 2'b10;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic periph_irq = 0, xfer_done = 0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic irq_out, periph_rst, dma_en;

    int total = 0, failed = 0;
    bit done = 0;

    logic [31:0] m_ctrl, m_addr, m_cnt, m_high;
    logic m_pend;

    always #10 clk = ~clk;

    dma_chan_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (.*);

    function automatic logic [31:0] exp_ctrl(input logic [31:0] old, input logic [31:0] v);
        logic [31:0] n = v;
        if (!v[7]) begin
            if (v[6]) n[6] = 1'b0;
            else if (v == 32'd0) n[6] = 1'b1;
        end
        return (old & RO) | (n & ~RO) | VER;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] idx, input logic [1:0] size, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1; bus_size = size;
        bus_addr = {4'($urandom_range(0, 15)), idx, 2'($urandom_range(0, 3))};
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 0; bus_size = 2'b10;
    endtask

    task automatic compare_all(input string req);
        logic [31:0] v;
        rd(2'd0, 2'b10, v); check({req, " ctrl"}, v, m_ctrl | {31'd0, m_pend});
        rd(2'd1, 2'b10, v); check({req, " addr"}, v, m_addr);
        rd(2'd2, 2'b10, v); check({req, " count"}, v, m_cnt);
        rd(2'd3, 2'b10, v); check({req, " high"}, v, m_high);
        check({req, " irq_out R5"}, {31'd0, irq_out}, {31'd0, m_pend & m_ctrl[4]});
        check({req, " dma_en R8"}, {31'd0, dma_en}, {31'd0, m_ctrl[9]});
        check({req, " periph_rst R6"}, {31'd0, periph_rst}, 32'd0);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d, input logic [1:0] size);
        @(negedge clk);
        bus_wr = 1; bus_wdata = d; bus_size = size;
        bus_addr = {4'($urandom_range(0, 15)), idx, 2'($urandom_range(0, 3))};
        @(negedge clk);
        bus_wr = 0; bus_size = 2'b10;
        if (size == 2'b10) begin
            case (idx)
                2'd0: m_ctrl = exp_ctrl(m_ctrl, d);
                2'd1: begin m_addr = d; m_ctrl[26] = 1'b1; end
                2'd2: m_cnt = d;
                default: m_high = d;
            endcase
        end
        check("R6 pulse after write", {31'd0, periph_rst},
              {31'd0, (size == 2'b10 && idx == 2'd0 && d[7])});
        check("R8 enable after write", {31'd0, dma_en}, {31'd0, m_ctrl[9]});
        @(negedge clk);
        check("R6 pulse ends", {31'd0, periph_rst}, 32'd0);
    endtask

    task automatic set_irq(input logic lvl);
        @(negedge clk);
        periph_irq = lvl;
        @(negedge clk);
        m_pend = lvl;
        check("R5 irq gate", {31'd0, irq_out}, {31'd0, m_pend & m_ctrl[4]});
    endtask

    task automatic xfer(input logic [LEN_W-1:0] n);
        @(negedge clk);
        xfer_done = 1; xfer_len = n;
        @(negedge clk);
        xfer_done = 0;
        m_addr = m_addr + 32'(n);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        m_ctrl = VER; m_addr = 0; m_cnt = 0; m_high = 0; m_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 periph_rst", {31'd0, periph_rst}, 32'd0);
        check("R1 dma_en", {31'd0, dma_en}, 32'd0);
        check("R1 irq_out", {31'd0, irq_out}, 32'd0);
        rd(2'd0, 2'b10, v); check("R1 ctrl value", v, 32'hA000_0000);
        compare_all("R1");

        // R11 non-word accesses ignored / read zero
        wr(2'd2, 32'h1234_5678, 2'b01);
        wr(2'd0, 32'h0000_0280, 2'b00);
        rd(2'd0, 2'b01, v); check("R11 non-word read", v, 32'd0);
        compare_all("R11");

        // R12 count/high; R2 decode with random upper bits
        wr(2'd2, 32'hCAFE_0001, 2'b10);
        wr(2'd3, 32'h0000_00FF, 2'b10);
        compare_all("R12 R2");

        // R7 drain handling
        wr(2'd0, 32'd0, 2'b10);
        rd(2'd0, 2'b10, v); check("R7 zero write sets drain", v, 32'hA000_0040);
        wr(2'd0, 32'h0000_0040, 2'b10);
        rd(2'd0, 2'b10, v); check("R7 drain write cleared", v, 32'hA000_0000);
        wr(2'd0, 32'h0000_00C0, 2'b10);
        rd(2'd0, 2'b10, v); check("R7 reset keeps drain", v, 32'hA000_00C0);

        // R3 read-only protection
        wr(2'd0, 32'hFFFF_FF7F, 2'b10);
        rd(2'd0, 2'b10, v); check("R3 ro bits", v, 32'hA1FF_FF38);
        wr(2'd0, 32'h0000_0100, 2'b10);
        compare_all("R3");

        // R9 loaded bit
        wr(2'd1, 32'h0000_1000, 2'b10);
        rd(2'd0, 2'b10, v); check("R9 loaded set", {31'd0, v[26]}, 32'd1);
        wr(2'd0, 32'h0000_0010, 2'b10);
        rd(2'd0, 2'b10, v); check("R9 loaded sticky", {31'd0, v[26]}, 32'd1);

        // R4 R5 pending and gating
        set_irq(1);
        rd(2'd0, 2'b10, v); check("R4 pending set", {31'd0, v[0]}, 32'd1);
        check("R5 irq high", {31'd0, irq_out}, 32'd1);
        wr(2'd1, 32'h0000_2000, 2'b10); // write cannot clear pending
        wr(2'd0, 32'h0000_0001, 2'b10);
        check("R5 enable dropped", {31'd0, irq_out}, 32'd0);
        rd(2'd0, 2'b10, v); check("R4 write keeps pending", {31'd0, v[0]}, 32'd1);
        set_irq(0);

        // R10 transfer increments, write wins
        xfer(16'd64);
        xfer(16'hFFFF);
        compare_all("R10");
        @(negedge clk);
        xfer_done = 1; xfer_len = 16'd8;
        bus_wr = 1; bus_addr = 8'h04; bus_size = 2'b10; bus_wdata = 32'h5555_0000;
        @(negedge clk);
        bus_wr = 0; xfer_done = 0;
        m_addr = 32'h5555_0000; m_ctrl[26] = 1'b1;
        rd(2'd1, 2'b10, v); check("R10 write beats increment", v, 32'h5555_0000);

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            logic [31:0] d = $urandom();
            if (op <= 3) begin
                if ($urandom_range(0, 5) == 0) d = 32'd0;
                else if ($urandom_range(0, 2) != 0) d[7] = 1'b0;
                wr(2'd0, d, 2'b10);
            end else if (op == 4) wr(2'($urandom_range(1, 3)), d, 2'b10);
            else if (op == 5) wr(2'($urandom_range(0, 3)), d, 2'($urandom_range(0, 1)));
            else if (op == 6) set_irq(1'($urandom_range(0, 1)));
            else if (op == 7) xfer(LEN_W'($urandom()));
            else compare_all("R2 R3 R10 R12 random");
        end
        compare_all("final");

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule